// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block picks which resident warp issues its next instruction in each cycle. A warp is a group of 32 threads that share one instruction stream. A single issue sends one instruction to all 32 lanes of the execution array, and that instruction takes one issue cycle. The scheduler keeps a slot for every warp that can be resident, up to `NUM_WARPS` (64 by default: 2048 threads split into groups of 32). A warp takes a free slot through a launch handshake and gives the slot back when it raises an exit request.

A warp may issue only when all of these hold:
- it is resident;
- its instruction supply reports that an instruction is ready;
- it has no register-dependency stall;
- it is not waiting on a long-latency memory access.

When an issued instruction is a memory access, the warp stops being eligible. It becomes eligible again either when a reply tagged with its ID returns or when a latency window of `MEM_LAT` cycles runs out, whichever comes first. `MEM_LAT` is meant to be set between 100 and 400. The scheduler switches between warps every cycle with no penalty cycles. Selection is round-robin and starts from the warp after the last one issued. Cycles in which nothing can issue are counted.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `issue_valid` is 0, `idle_count` is 0, every slot is free, `launch_ready` is 1 and `launch_slot` is 0.
- R2: At most one warp issues per cycle, and `issue_valid` is combinational in the same cycle. The issued warp is resident, has `inst_avail` set, has `dep_stall` clear, is not waiting on memory and is not exiting.
- R3: The scheduler searches for eligible warps in increasing index order, wrapping at the top, starting from the warp after the last one issued. If any warp other than the last issued one is eligible, that other warp issues in the very next cycle, with no gap cycle.
- R4: If a single warp is the only eligible one, it may issue on back-to-back cycles.
- R5: If the issuing warp has `mem_op[id]`=1 and no reply arrives, that warp is ineligible for exactly `MEM_LAT` following cycles and is eligible in the cycle after those.
- R6: `mem_done_valid` with `mem_done_id`=w clears warp w's memory wait, and w can issue in the next cycle. A reply carrying a different ID does not wake w.
- R7: In a cycle with no eligible warp, `issue_valid` is 0 and `idle_count` increases by 1 at the next edge, saturating at its maximum.
- R8: `launch_ready` is 1 while any slot is free. `launch_slot` gives the lowest free slot index. When `launch_valid` and `launch_ready` are both 1, that slot is resident from the next cycle with no memory wait.
- R9: `exit_valid` with `exit_id`=w blocks w from issuing in that same cycle and frees slot w from the next cycle.
- R10: `inst_avail` and `dep_stall` bits of warps that are not resident have no effect on issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Request to place a new warp |
| launch_ready | output | 1 | A free slot exists |
| launch_slot | output | WID_W | Slot the next launch will take |
| inst_avail | input | NUM_WARPS | Per-warp next-instruction-ready flags |
| dep_stall | input | NUM_WARPS | Per-warp register dependency stall |
| mem_op | input | NUM_WARPS | Per-warp flag: next instruction is a long-latency memory access |
| exit_valid | input | 1 | Warp retire request |
| exit_id | input | WID_W | Warp being retired |
| mem_done_valid | input | 1 | Memory reply returned |
| mem_done_id | input | WID_W | Warp the reply belongs to |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_id | output | WID_W | Warp that issues |
| idle_count | output | CNT_W | Saturating count of cycles with no issue |

## Verification
The hardest state to reach from the ports is a warp that sits in the memory wait while other activity goes on around it. The timeout has to be measured to the exact cycle, and a reply tagged for a different warp must be shown not to wake it. The stimulus first makes a lone eligible warp issue a memory operation. It then holds that warp's `inst_avail` high for the whole window, so that any early wake-up shows at once as an issue. A second sequence sends a reply with the wrong tag and then one with the right tag, and watches the cycle in which the issue returns. Round-robin order is walked through a table of availability and dependency masks, each entry with a hand-computed winner.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  localparam int LAT_W = 9;

  typedef struct packed {
    logic resident;
    logic mem_wait;
  } warp_stat_t;

  function automatic logic [LAT_W-1:0] lat_load(input int lat);
    return LAT_W'(lat - 1);
  endfunction

endpackage

// File: rtl/wsch_free_find.sv
module wsch_free_find #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [N-1:0] resident,
  output logic         any_free,
  output logic [W-1:0] slot
);

  function automatic logic [W:0] lowest_zero(input logic [N-1:0] v);
    logic [W:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v[i]) r = {1'b1, W'(i)};
    end
    return r;
  endfunction

  logic [W:0] res;
  assign res      = lowest_zero(resident);
  assign any_free = res[W];
  assign slot     = res[W-1:0];

endmodule

// File: rtl/wsch_rr_pick.sv
module wsch_rr_pick #(
  parameter int N = 64,
  parameter int W = 6
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] last,
  output logic         found,
  output logic [W-1:0] pick
);

  function automatic logic [W:0] rr_search(input logic [N-1:0] r, input logic [W-1:0] start);
    logic [W:0] res;
    int j;
    res = '0;
    for (int i = 0; i < N; i++) begin
      j = int'(start) + i;
      if (j >= N) j = j - N;
      if (!res[W] && r[j]) res = {1'b1, W'(j)};
    end
    return res;
  endfunction

  logic [W-1:0] start;
  logic [W:0]   res;

  assign start = (int'(last) == N - 1) ? '0 : last + W'(1);
  assign res   = rr_search(req, start);
  assign found = res[W];
  assign pick  = res[W-1:0];

endmodule

// File: rtl/wsch_warp_slot.sv
module wsch_warp_slot
  import warp_sched_pkg::*;
#(
  parameter int MEM_LAT = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_hit,
  input  logic       exit_hit,
  input  logic       issue_mem_hit,
  input  logic       done_hit,
  output warp_stat_t stat
);

  logic [LAT_W-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat    <= '0;
      lat_cnt <= '0;
    end else if (exit_hit) begin
      stat.resident <= 1'b0;
      stat.mem_wait <= 1'b0;
    end else if (launch_hit) begin
      stat.resident <= 1'b1;
      stat.mem_wait <= 1'b0;
    end else if (issue_mem_hit) begin
      stat.mem_wait <= 1'b1;
      lat_cnt       <= lat_load(MEM_LAT);
    end else if (stat.mem_wait) begin
      if (done_hit || lat_cnt == '0) stat.mem_wait <= 1'b0;
      else                           lat_cnt <= lat_cnt - 1'b1;
    end
  end

  // R5: a waiting warp stays blocked while its window still runs
  assert_mem_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.mem_wait && lat_cnt != '0 && !done_hit && !exit_hit) |=> stat.mem_wait);

  // R6: a matching reply ends the wait at the next edge
  assert_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.mem_wait && done_hit && !exit_hit) |=> !stat.mem_wait);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = 64,
  parameter int MEM_LAT   = 200,
  parameter int CNT_W     = 32,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  output logic                 launch_ready,
  output logic [WID_W-1:0]     launch_slot,
  input  logic [NUM_WARPS-1:0] inst_avail,
  input  logic [NUM_WARPS-1:0] dep_stall,
  input  logic [NUM_WARPS-1:0] mem_op,
  input  logic                 exit_valid,
  input  logic [WID_W-1:0]     exit_id,
  input  logic                 mem_done_valid,
  input  logic [WID_W-1:0]     mem_done_id,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_id,
  output logic [CNT_W-1:0]     idle_count
);

  logic [NUM_WARPS-1:0] resident;
  logic [NUM_WARPS-1:0] waiting;
  logic [NUM_WARPS-1:0] exiting;
  logic [NUM_WARPS-1:0] eligible;
  logic [WID_W-1:0]     last_q;
  logic                 launch_fire;

  assign launch_fire = launch_valid && launch_ready;
  assign eligible    = resident & inst_avail & ~dep_stall & ~waiting & ~exiting;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    warp_stat_t st;
    assign exiting[w] = exit_valid && (exit_id == WID_W'(w));
    wsch_warp_slot #(.MEM_LAT(MEM_LAT)) slot_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch_hit   (launch_fire && (launch_slot == WID_W'(w))),
      .exit_hit     (exiting[w]),
      .issue_mem_hit(issue_valid && (issue_id == WID_W'(w)) && mem_op[w]),
      .done_hit     (mem_done_valid && (mem_done_id == WID_W'(w))),
      .stat         (st)
    );
    assign resident[w] = st.resident;
    assign waiting[w]  = st.mem_wait;
  end

  wsch_free_find #(.N(NUM_WARPS), .W(WID_W)) free_i (
    .resident(resident),
    .any_free(launch_ready),
    .slot    (launch_slot)
  );

  wsch_rr_pick #(.N(NUM_WARPS), .W(WID_W)) pick_i (
    .req  (eligible),
    .last (last_q),
    .found(issue_valid),
    .pick (issue_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q     <= WID_W'(NUM_WARPS - 1);
      idle_count <= '0;
    end else begin
      if (issue_valid) last_q <= issue_id;
      else if (idle_count != '1) idle_count <= idle_count + 1'b1;
    end
  end

  // R2: the issued warp really is ready
  assert_issue_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (resident[issue_id] && inst_avail[issue_id] &&
                     !dep_stall[issue_id] && !waiting[issue_id] && !exiting[issue_id]));

  // R3: with a second candidate, issue moves to another warp
  assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && $past(issue_valid) && $countones(eligible) > 1) |-> (issue_id != $past(issue_id)));

  // R7: idle cycles are counted
  assert_idle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_valid && idle_count != '1) |=> (idle_count == $past(idle_count) + 1'b1));

  // R8: an accepted launch makes the slot resident
  assert_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fire |=> resident[$past(launch_slot)]);

  // R9: a retired warp frees its slot
  assert_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_valid && resident[exit_id]) |=> !resident[$past(exit_id)]);

endmodule

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NW  = 8;
  localparam int LAT = 100;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          launch_valid = 1'b0;
  logic          launch_ready;
  logic [2:0]    launch_slot;
  logic [NW-1:0] inst_avail = '0;
  logic [NW-1:0] dep_stall = '0;
  logic [NW-1:0] mem_op = '0;
  logic          exit_valid = 1'b0;
  logic [2:0]    exit_id = '0;
  logic          mem_done_valid = 1'b0;
  logic [2:0]    mem_done_id = '0;
  logic          issue_valid;
  logic [2:0]    issue_id;
  logic [CW-1:0] idle_count;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .MEM_LAT(LAT), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_ready(launch_ready), .launch_slot(launch_slot),
    .inst_avail(inst_avail), .dep_stall(dep_stall), .mem_op(mem_op),
    .exit_valid(exit_valid), .exit_id(exit_id),
    .mem_done_valid(mem_done_valid), .mem_done_id(mem_done_id),
    .issue_valid(issue_valid), .issue_id(issue_id), .idle_count(idle_count)
  );

  // {avail, dep, expected valid, expected id}
  localparam logic [19:0] VEC [0:14] = '{
    {8'h0F, 8'h00, 1'b1, 3'd0},
    {8'h0F, 8'h00, 1'b1, 3'd1},
    {8'h0F, 8'h00, 1'b1, 3'd2},
    {8'h0F, 8'h04, 1'b1, 3'd3},
    {8'h0F, 8'h01, 1'b1, 3'd1},
    {8'h0F, 8'h0E, 1'b1, 3'd0},
    {8'h01, 8'h00, 1'b1, 3'd0},
    {8'h00, 8'h00, 1'b0, 3'd0},
    {8'hF0, 8'h00, 1'b0, 3'd0},
    {8'h0F, 8'h0F, 1'b0, 3'd0},
    {8'h0C, 8'h00, 1'b1, 3'd2},
    {8'h0C, 8'h00, 1'b1, 3'd3},
    {8'h0C, 8'h00, 1'b1, 3'd2},
    {8'h09, 8'h00, 1'b1, 3'd3},
    {8'h09, 8'h00, 1'b1, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #2;
  endtask

  initial begin
    int cnt;
    cnt = 0;
    while (cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    nerr++;
    $display("FAIL watchdog actual=%0d expected=0", cnt);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [CW-1:0] base;
    int bad;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    chk("R1 issue_valid", 32'(issue_valid), 0);
    chk("R1 idle_count", 32'(idle_count), 0);
    chk("R1 launch_ready", 32'(launch_ready), 1);
    chk("R1 launch_slot", 32'(launch_slot), 0);

    // R8: fill slots 0..3
    tick();
    for (int i = 0; i < 4; i++) begin
      launch_valid = 1'b1;
      settle();
      chk("R8 launch_slot", 32'(launch_slot), 32'(i));
      tick();
    end
    launch_valid = 1'b0;

    // R3 R4 R10: table walk
    settle();
    base = idle_count;
    for (int i = 0; i < 15; i++) begin
      inst_avail = VEC[i][19:12];
      dep_stall  = VEC[i][11:4];
      settle();
      chk("R3/R10 issue_valid", 32'(issue_valid), 32'(VEC[i][3]));
      if (VEC[i][3]) chk("R3/R4 issue_id", 32'(issue_id), 32'(VEC[i][2:0]));
      tick();
    end
    inst_avail = '0;
    dep_stall  = '0;
    settle();
    chk("R7 idle_count delta", 32'(idle_count - base), 3);

    // R5: timeout window on warp 0
    inst_avail = 8'h01;
    mem_op     = 8'h01;
    settle();
    chk("R5 mem issue id", 32'(issue_valid ? issue_id : 3'd7), 0);
    tick();
    mem_op = '0;
    bad = 0;
    for (int i = 0; i < LAT; i++) begin
      settle();
      if (issue_valid) bad++;
      tick();
    end
    chk("R5 issues inside window", 32'(bad), 0);
    settle();
    chk("R5 eligible after window", 32'(issue_valid), 1);
    chk("R5 id after window", 32'(issue_id), 0);
    tick();

    // R6: reply wakes warp 1
    inst_avail = 8'h02;
    mem_op     = 8'h02;
    settle();
    chk("R6 mem issue id", 32'(issue_valid ? issue_id : 3'd7), 1);
    tick();
    mem_op = '0;
    repeat (5) tick();
    mem_done_valid = 1'b1;
    mem_done_id    = 3'd1;
    settle();
    chk("R6 still blocked in reply cycle", 32'(issue_valid), 0);
    tick();
    mem_done_valid = 1'b0;
    settle();
    chk("R6 woken warp issues", 32'(issue_valid ? issue_id : 3'd7), 1);
    tick();

    // R6: reply for another warp does not wake warp 0
    inst_avail = 8'h01;
    mem_op     = 8'h01;
    settle();
    chk("R6 mem issue id w0", 32'(issue_valid ? issue_id : 3'd7), 0);
    tick();
    mem_op = '0;
    mem_done_valid = 1'b1;
    mem_done_id    = 3'd3;
    tick();
    mem_done_id = 3'd0;
    settle();
    chk("R6 other reply ignored", 32'(issue_valid), 0);
    tick();
    mem_done_valid = 1'b0;
    settle();
    chk("R6 own reply wakes", 32'(issue_valid ? issue_id : 3'd7), 0);
    tick();

    // R9: exit warp 3
    inst_avail = 8'h08;
    exit_valid = 1'b1;
    exit_id    = 3'd3;
    settle();
    chk("R9 no issue while exiting", 32'(issue_valid), 0);
    tick();
    exit_valid = 1'b0;
    settle();
    chk("R9 exited warp not issued", 32'(issue_valid), 0);
    chk("R9 freed slot offered", 32'(launch_slot), 3);
    inst_avail = '0;
    tick();

    // R8: refill to full
    for (int i = 3; i < 8; i++) begin
      launch_valid = 1'b1;
      settle();
      chk("R8 launch_slot refill", 32'(launch_slot), 32'(i));
      tick();
    end
    settle();
    chk("R8 launch_ready when full", 32'(launch_ready), 0);
    tick();
    launch_valid = 1'b0;
    inst_avail   = 8'h80;
    settle();
    chk("R8 launched warp issues", 32'(issue_valid ? issue_id : 3'd0), 7);
    tick();
    inst_avail = '0;

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule